// File: doc/BRIEF.md
# Page-Table IO Address Translator

This block sits between an I/O bus that issues DMA addresses and the system memory fabric. For every DMA address it decides whether the address is used as-is or remapped through a one-level page directory that software has placed in system memory. A remapping costs one 64-bit memory read of the directory entry. The result is either the remapped address or a fault.

Software sets up three configuration registers: a window base with an enable flag, a window mask and a directory base. It writes them 32 or 64 bits at a time. Two more registers, a purge command and a translation configuration, are held and read back but do not take part in translation. Requests and responses use valid/ready handshakes, and only one request is in flight at a time.

The controller has four states. `ST_IDLE` accepts a request. `ST_FETCH` presents the directory read. `ST_WAIT` waits for the read data. `ST_RESP` holds the response. The transitions are:
- IDLE to RESP on a pass-through request.
- IDLE to FETCH on a request inside an enabled window.
- FETCH to WAIT when the memory port takes the read.
- WAIT to RESP when the read data arrives.
- RESP to IDLE when the response is taken.

Top module: `dma_xlat_top`

## Requirements
- R1: After reset all five configuration registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: The registers sit at byte offsets 0x20300 (window base), 0x20308 (window mask), 0x20310 (purge command), 0x20318 (translation config) and 0x20320 (directory base). A write with `cfg_wide`=1 replaces all 64 bits. A write with `cfg_wide`=0 takes `cfg_wdata[31:0]` into bits 31:0 when `cfg_addr[2]`=0, or into bits 63:32 when `cfg_addr[2]`=1, and leaves the other half unchanged. `cfg_rdata` always shows the full 64-bit register at `cfg_addr`.
- R3: When bit 0 of the window base is 0, a request is answered with its own address and no fault. No memory read is made, and `rsp_valid` is high one cycle after the request is accepted.
- R4: When bit 0 of the window base is 1 and (address AND mask) differs from the base with bit 0 cleared, the request passes through unchanged without a memory read.
- R5: A request inside an enabled window issues exactly one memory read, at address directory base + (request address >> 12) * 8.
- R6: The read data is a 64-bit little-endian entry (`mem_rdata[7:0]` is the lowest-addressed byte). If bit 63 is 1, the response address is the entry with bit 63 and bits 11:0 cleared, ORed with request bits 11:0, and the fault flag is 0.
- R7: If entry bit 63 is 0, the response carries fault=1 and address zero.
- R8: `req_ready` is high only while no request is in flight. `rsp_valid` and the response fields stay stable until `rsp_ready`. `mem_rd_valid` and `mem_rd_addr` stay stable until `mem_rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit half write |
| cfg_addr | input | 18 | Configuration byte offset (write and read) |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Register at cfg_addr |
| req_valid | input | 1 | DMA address request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | DMA address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_addr | output | 64 | Resulting system address |
| rsp_fault | output | 1 | Directory entry invalid |
| mem_rd_valid | output | 1 | Directory read request |
| mem_rd_ready | input | 1 | Memory took the read |
| mem_rd_addr | output | 64 | Directory entry address |
| mem_rdata_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Directory entry data |

## Verification
Translation is tried with these patterns:
- An address inside the window while the enable flag is clear, which separates the enable gating from the window compare.
- An enabled window with an address outside it, which shows the mask compare on its own.
- In-window addresses whose entries are valid and invalid, which separate remapping from faulting.

The first and last addresses at the window edge show that the compare honours every mask bit. Slow memory handshakes and a delayed `rsp_ready` show that outputs hold while stalled. Half-width writes to both halves of one register show that the halves are selected independently.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    // register slot order inside the configuration block
    localparam int SLOT_WBASE = 0;
    localparam int SLOT_WMASK = 1;
    localparam int SLOT_PURGE = 2;
    localparam int SLOT_TCFG  = 3;
    localparam int SLOT_DIR   = 4;
    localparam int NUM_SLOTS  = 5;
endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs #(
    parameter int                 DW        = 64,
    parameter int                 CFG_AW    = 18,
    parameter logic [CFG_AW-1:0]  BASE_OFFS = 18'h20300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wide,
    input  logic [CFG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     win_base,
    output logic [DW-1:0]     win_mask,
    output logic [DW-1:0]     dir_base
);
    import xlat_pkg::*;

    localparam int HW = DW / 2;

    logic [DW-1:0] slot_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [CFG_AW-1:0] OFFS = BASE_OFFS + CFG_AW'(8 * i);
        logic [DW-1:0] q;

        assign hit[i] = (addr[CFG_AW-1:3] == OFFS[CFG_AW-1:3]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && hit[i]) begin
                if (wide) begin
                    q <= wdata;
                end else if (addr[2]) begin
                    q[DW-1:HW] <= wdata[HW-1:0];
                end else begin
                    q[HW-1:0] <= wdata[HW-1:0];
                end
            end
        end

        assign slot_q[i] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) rdata = slot_q[i];
        end
    end

    assign win_base = slot_q[SLOT_WBASE];
    assign win_mask = slot_q[SLOT_WMASK];
    assign dir_base = slot_q[SLOT_DIR];
endmodule

// File: rtl/xlat_window.sv
module xlat_window #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int ENT_LOG2   = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_mask,
    input  logic [AW-1:0] dir_base,
    output logic          in_window,
    output logic [AW-1:0] entry_addr
);
    logic [AW-1:0] base_cmp;
    logic [AW-1:0] page_idx;

    assign base_cmp   = {win_base[AW-1:1], 1'b0};
    assign in_window  = win_base[0] && ((addr & win_mask) == base_cmp);
    assign page_idx   = addr >> PAGE_SHIFT;
    assign entry_addr = dir_base + (page_idx << ENT_LOG2);
endmodule

// File: rtl/xlat_engine.sv
module xlat_engine #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          in_window,
    input  logic [AW-1:0] entry_addr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_fault,
    output logic          mem_rd_valid,
    input  logic          mem_rd_ready,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rdata_valid,
    input  logic [AW-1:0] mem_rdata
);
    import xlat_pkg::*;

    localparam logic [AW-1:0] OFFS_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

    xl_state_e     state_q, state_d;
    logic [AW-1:0] ent_q;
    logic [AW-1:0] lo_q;
    logic [AW-1:0] res_q;
    logic          flt_q;
    logic          accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)       state_d = in_window ? ST_FETCH : ST_RESP;
            ST_FETCH: if (mem_rd_ready)    state_d = ST_WAIT;
            ST_WAIT:  if (mem_rdata_valid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ready)       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            lo_q  <= '0;
            res_q <= '0;
            flt_q <= 1'b0;
        end else begin
            if (accept) begin
                ent_q <= entry_addr;
                lo_q  <= req_addr & OFFS_MASK;
                res_q <= req_addr;
                flt_q <= 1'b0;
            end
            if (state_q == ST_WAIT && mem_rdata_valid) begin
                if (mem_rdata[AW-1]) begin
                    res_q <= ({1'b0, mem_rdata[AW-2:0]} & ~OFFS_MASK) | lo_q;
                    flt_q <= 1'b0;
                end else begin
                    res_q <= '0;
                    flt_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_FETCH);
        rsp_valid    = (state_q == ST_RESP);
        mem_rd_addr  = ent_q;
        rsp_addr     = res_q;
        rsp_fault    = flt_q;
    end
endmodule

// File: rtl/dma_xlat_top.sv
module dma_xlat_top #(
    parameter int                AW         = 64,
    parameter int                CFG_AW     = 18,
    parameter logic [CFG_AW-1:0] BASE_OFFS  = 18'h20300,
    parameter int                PAGE_SHIFT = 12,
    parameter int                ENT_LOG2   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wide,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [AW-1:0]     rsp_addr,
    output logic              rsp_fault,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rdata_valid,
    input  logic [AW-1:0]     mem_rdata
);
    logic [AW-1:0] win_base, win_mask, dir_base, entry_addr;
    logic          in_window;

    xlat_cfg_regs #(.DW(AW), .CFG_AW(CFG_AW), .BASE_OFFS(BASE_OFFS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wide(cfg_wide),
        .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .win_base(win_base), .win_mask(win_mask), .dir_base(dir_base)
    );

    xlat_window #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .ENT_LOG2(ENT_LOG2)) u_win (
        .addr(req_addr), .win_base(win_base), .win_mask(win_mask),
        .dir_base(dir_base), .in_window(in_window), .entry_addr(entry_addr)
    );

    xlat_engine #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .in_window(in_window), .entry_addr(entry_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rdata_valid(mem_rdata_valid),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_fault,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [AW-1:0] mem_rd_addr
);
    logic [11:0] last_lo;

    always_ff @(posedge clk) begin
        if (!rst_n)                      last_lo <= '0;
        else if (req_valid && req_ready) last_lo <= req_addr[11:0];
    end

    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_one_inflight_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_rd_valid)));

    assert_page_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_addr[11:0] == last_lo));
endmodule

bind dma_xlat_top xlat_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr)
);

// File: tb/sim_dma_xlat_top.sv
`timescale 1ns/1ps
module sim_dma_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wide = 1'b0;
    logic [17:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0, cfg_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_ready = 1'b0, rsp_fault;
    logic [63:0] rsp_addr;
    logic        mem_rd_valid, mem_rd_ready = 1'b0, mem_rdata_valid = 1'b0;
    logic [63:0] mem_rd_addr, mem_rdata = '0;

    int n_checks = 0, n_fail = 0, nreads = 0, lat = 0;
    logic [63:0] seen_rd_addr = '0, dir_sh = '0;
    logic [63:0] pt [64];
    bit done = 0;

    always #10 clk = ~clk;

    dma_xlat_top u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                repeat (lat) @(negedge clk);
                mem_rd_ready = 1'b1;
                seen_rd_addr = mem_rd_addr;
                nreads++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                repeat (lat) @(negedge clk);
                mem_rdata = pt[6'((seen_rd_addr - dir_sh) >> 3)];
                mem_rdata_valid = 1'b1;
                @(negedge clk);
                mem_rdata_valid = 1'b0;
            end
        end
    end

    task automatic cfg_wr(input logic [17:0] a, input logic [63:0] d, input bit w);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_wide = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_rd_chk(input logic [17:0] a, input logic [63:0] e, input string req);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == e, req, cfg_rdata, e);
    endtask

    task automatic do_xlat(input logic [63:0] a, input logic [63:0] ea, input bit ef,
                           input int ereads, input logic [63:0] erd, input int hold,
                           input string req);
        int r0, n;
        logic [63:0] held;
        @(negedge clk);
        r0 = nreads;
        req_valid = 1'b1; req_addr = a;
        chk(req_ready == 1'b1, "R8 ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", 64'(req_ready), 64'd0);
        n = 0;
        while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
        if (ereads == 0) chk(n == 0, "R3 pass-through latency", 64'(n), 64'd0);
        chk(rsp_addr == ea, req, rsp_addr, ea);
        chk(rsp_fault == ef, req, 64'(rsp_fault), 64'(ef));
        chk(nreads - r0 == ereads, "R5 read count", 64'(nreads - r0), 64'(ereads));
        if (ereads != 0) chk(seen_rd_addr == erd, "R5 entry address", seen_rd_addr, erd);
        held = rsp_addr;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_addr == held && !req_ready, "R8 response held",
                rsp_addr, held);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8 response retired", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [63:0] remap(input logic [63:0] ent, input logic [63:0] a);
        return (ent & 64'h7FFF_FFFF_FFFF_F000) | (a & 64'hFFF);
    endfunction

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(!rsp_valid && !mem_rd_valid, "R1 idle outputs", 64'({rsp_valid, mem_rd_valid}), 64'd0);
        for (int i = 0; i < 5; i++) cfg_rd_chk(18'h20300 + 18'(8 * i), 64'd0, "R1 register zero");
    endtask

    task automatic t_regs;
        cfg_wr(18'h20318, 64'h1122_3344_5566_7788, 1'b1);
        cfg_rd_chk(18'h20318, 64'h1122_3344_5566_7788, "R2 wide write");
        cfg_wr(18'h20310, 64'hFFFF_FFFF_AAAA_5555, 1'b0);
        cfg_rd_chk(18'h20310, 64'h0000_0000_AAAA_5555, "R2 low half");
        cfg_wr(18'h20314, 64'h0000_0000_1234_5678, 1'b0);
        cfg_rd_chk(18'h20310, 64'h1234_5678_AAAA_5555, "R2 high half");
        cfg_wr(18'h2031C, 64'h0000_0000_CAFE_F00D, 1'b0);
        cfg_rd_chk(18'h20318, 64'hCAFE_F00D_5566_7788, "R2 high half keeps low");
    endtask

    task automatic t_disabled;
        cfg_wr(18'h20308, 64'hFFFF_FFFF_FF00_0000, 1'b1);
        cfg_wr(18'h20300, 64'h0000_0000_4000_0000, 1'b1);
        cfg_wr(18'h20320, 64'h0000_0000_0010_0000, 1'b1);
        dir_sh = 64'h0010_0000;
        do_xlat(64'h4000_3ABC, 64'h4000_3ABC, 1'b0, 0, 64'd0, 0, "R3 disabled pass-through");
    endtask

    task automatic t_outside;
        cfg_wr(18'h20300, 64'h0000_0000_4000_0001, 1'b1);
        do_xlat(64'h5000_1234, 64'h5000_1234, 1'b0, 0, 64'd0, 0, "R4 outside window");
        do_xlat(64'h4100_0000, 64'h4100_0000, 1'b0, 0, 64'd0, 0, "R4 just above window");
    endtask

    task automatic t_valid;
        do_xlat(64'h4000_3ABC, remap(pt[3], 64'h4000_3ABC), 1'b0, 1,
                64'h0010_0000 + (64'h4000_3ABC >> 12) * 8, 0, "R6 valid entry");
        do_xlat(64'h40FF_FFFF, remap(pt[63], 64'h40FF_FFFF), 1'b0, 1,
                64'h0010_0000 + (64'h40FF_FFFF >> 12) * 8, 0, "R6 window top edge");
    endtask

    task automatic t_fault;
        do_xlat(64'h4000_7123, 64'd0, 1'b1, 1,
                64'h0010_0000 + (64'h4000_7123 >> 12) * 8, 0, "R7 invalid entry");
    endtask

    task automatic t_stall;
        lat = 3;
        do_xlat(64'h4000_0001, remap(pt[0], 64'h4000_0001), 1'b0, 1,
                64'h0010_0000 + (64'h4000_0001 >> 12) * 8, 3, "R8 stalled translation");
        lat = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++)
            pt[i] = {1'b1, 7'd0, 24'(i * 24'h1357), 20'(i * 20'h0BEEF), 12'hFFF};
        pt[7] = 64'h0000_1234_5678_9000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_disabled;
        t_outside;
        t_valid;
        t_fault;
        t_stall;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule